// File: doc/BRIEF.md
# Dual-Read Lane Operand Buffer with Shareable Bank

Each processing lane has one operand store that feeds an execution unit two operands per cycle. The store holds two banks. The private bank is reachable only by its own lane. The shared bank can also be read by a neighbouring lane, so a kernel written into one lane's shared bank can feed every lane of the group. Each bank is split into an even half and an odd half. This gives the buffer two independent write ports: port 1 always fills the even half and port 2 always fills the odd half.

Reads are synchronous with one cycle of latency. No separate select lines are used: the operand pairing is chosen by bits of read address 1. Operand 2 always comes from the private bank. Operand 1 comes from one of three places: the private bank, this lane's shared bank, or the shared-data input that carries a neighbour's exported shared word. Every enabled cycle, the lane's own shared-bank read at read address 1 is exported on the shared-data output, but only while sharing is enabled.

The default sizing is 16-bit words, 128 private words and 32 shared words, with an 8-bit address.

Top module: `lane_opnd_buf`

## Requirements
- R1: After reset, while no enabled cycle has occurred, `rd_data1`, `rd_data2` and `shr_out` are all zero.
- R2: Address map:
  - Bit 0 selects the even half (0) or the odd half (1).
  - Bit 7 selects private space (0) or shared space (1).
  - The private word index is bits 6:1, so addresses 0–127 are private.
  - The shared word index is bits 4:1, so addresses 128–159 are shared.
- R3: Write port 1 writes only the even half and ignores its address bit 0. Write port 2 writes only the odd half and ignores its address bit 0. A port writes only when its strobe and `en` are both high. Bit 7 of the write address routes the write to the private or the shared bank. In shared space, bit 6 is ignored.
- R4: `rd_data2` shows, one cycle after an enabled cycle, the private word at `rd_addr2`. Bit 7 of `rd_addr2` is ignored.
- R5: When `rd_addr1` bit 7 is 0, `rd_data1` shows the private word at `rd_addr1` one cycle later. Any parity combination with `rd_addr2` is allowed, including both operands from the same half.
- R6: When `rd_addr1` bit 7 is 1 and bit 6 is 0, `rd_data1` shows this lane's shared word at `rd_addr1` one cycle later.
- R7: When `rd_addr1` bit 7 is 1 and bit 6 is 1, `rd_data1` follows `shr_in` from the following cycle on.
- R8: While `share_en` is 1, `shr_out` shows this lane's shared word at `rd_addr1` from the last enabled cycle, in every operand mode. While `share_en` is 0, `shr_out` is zero.
- R9: A read and a write to the same word in the same cycle return the old data. The new data is returned from the next read on.
- R10: While `en` is 0, no write takes effect and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Cycle enable for writes and reads |
| share_en | input | 1 | Allows export of shared-bank data |
| wr_en1 | input | 1 | Write strobe, even half |
| wr_addr1 | input | 8 | Write address, even half |
| wr_data1 | input | 16 | Write data, even half |
| wr_en2 | input | 1 | Write strobe, odd half |
| wr_addr2 | input | 8 | Write address, odd half |
| wr_data2 | input | 16 | Write data, odd half |
| rd_addr1 | input | 8 | Operand 1 address, also picks the operand mode |
| rd_addr2 | input | 8 | Operand 2 address, private only |
| shr_in | input | 16 | Shared word exported by a neighbour lane |
| shr_out | output | 16 | This lane's exported shared word |
| rd_data1 | output | 16 | Operand 1 |
| rd_data2 | output | 16 | Operand 2 |

## Verification
The bench first fills every word with a distinct pattern. It then sweeps operand pairings with a table:
- even/odd, odd/odd and same-half pairs;
- local shared reads;
- neighbour mode with changing `shr_in`;
- `shr_out` with sharing on and off.

A swapped half or a wrong index slice would show up as a neighbouring word's pattern. Directed tests cover three further cases:
- **Same-word read and write.** A write-first memory would return the new value one cycle early.
- **Even write address on the odd port.** A design that honoured bit 0 would drop or misplace the word. A shared write with bit 6 set would go astray if bit 6 were decoded.
- **Enable held low.** A leaky enable would let a write land or the outputs change.

// File: rtl/lane_opnd_buf_pkg.sv
package lane_opnd_buf_pkg;

    // Source of operand 1, one-hot
    typedef enum logic [2:0] {
        SRC_PRIV  = 3'b001,
        SRC_LOCAL = 3'b010,
        SRC_NBR   = 3'b100
    } src_e;

    typedef struct packed {
        src_e src;
        logic par1;   // half selected for operand 1
        logic par2;   // half selected for operand 2
    } steer_t;

endpackage

// File: rtl/lane_opnd_half.sv
// One half (even or odd) of a bank: one write port, NRD registered read ports.
module lane_opnd_half #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    parameter int NRD    = 2,
    parameter int IDX_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    we,
    input  logic [IDX_W-1:0]        waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NRD*IDX_W-1:0]    raddr,
    output logic [NRD*DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d [NRD];
    logic [DATA_W-1:0] rd_q [NRD];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        for (int k = 0; k < NRD; k++) begin
            rd_d[k] = en ? mem[raddr[k*IDX_W +: IDX_W]] : rd_q[k];
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rd_q[g] <= '0;
                end else begin
                    rd_q[g] <= rd_d[g];
                end
            end
            assign rdata[g*DATA_W +: DATA_W] = rd_q[g];

            assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !en |=> $stable(rdata[g*DATA_W +: DATA_W]));
        end
    endgenerate

endmodule

// File: rtl/lane_opnd_buf.sv
module lane_opnd_buf
    import lane_opnd_buf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PRIV_WORDS = 128,
    parameter int SHR_WORDS  = 32,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              share_en,
    input  logic              wr_en1,
    input  logic [ADDR_W-1:0] wr_addr1,
    input  logic [DATA_W-1:0] wr_data1,
    input  logic              wr_en2,
    input  logic [ADDR_W-1:0] wr_addr2,
    input  logic [DATA_W-1:0] wr_data2,
    input  logic [ADDR_W-1:0] rd_addr1,
    input  logic [ADDR_W-1:0] rd_addr2,
    input  logic [DATA_W-1:0] shr_in,
    output logic [DATA_W-1:0] shr_out,
    output logic [DATA_W-1:0] rd_data1,
    output logic [DATA_W-1:0] rd_data2
);

    localparam int SPACE_BIT = $clog2(PRIV_WORDS);
    localparam int NBR_BIT   = SPACE_BIT - 1;
    localparam int PIDX_W    = $clog2(PRIV_WORDS) - 1;
    localparam int SIDX_W    = $clog2(SHR_WORDS) - 1;
    localparam int PHALF     = PRIV_WORDS / 2;
    localparam int SHALF     = SHR_WORDS / 2;

    // Write and read routing
    logic [1:0]              priv_we, shr_we;
    logic [PIDX_W-1:0]       priv_widx [2];
    logic [SIDX_W-1:0]       shr_widx  [2];
    logic [DATA_W-1:0]       wdat      [2];
    logic [2*DATA_W-1:0]     priv_rd   [2];
    logic [DATA_W-1:0]       shr_rd    [2];
    logic [2*PIDX_W-1:0]     priv_raddr;
    logic [SIDX_W-1:0]       shr_raddr;

    assign priv_we[0] = en & wr_en1 & ~wr_addr1[SPACE_BIT];
    assign priv_we[1] = en & wr_en2 & ~wr_addr2[SPACE_BIT];
    assign shr_we[0]  = en & wr_en1 &  wr_addr1[SPACE_BIT];
    assign shr_we[1]  = en & wr_en2 &  wr_addr2[SPACE_BIT];

    assign priv_widx[0] = wr_addr1[PIDX_W:1];
    assign priv_widx[1] = wr_addr2[PIDX_W:1];
    assign shr_widx[0]  = wr_addr1[SIDX_W:1];
    assign shr_widx[1]  = wr_addr2[SIDX_W:1];
    assign wdat[0]      = wr_data1;
    assign wdat[1]      = wr_data2;

    assign priv_raddr = {rd_addr2[PIDX_W:1], rd_addr1[PIDX_W:1]};
    assign shr_raddr  = rd_addr1[SIDX_W:1];

    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            lane_opnd_half #(
                .DEPTH (PHALF), .DATA_W(DATA_W), .NRD(2), .IDX_W(PIDX_W)
            ) u_priv (
                .clk(clk), .rst_n(rst_n), .en(en),
                .we(priv_we[h]), .waddr(priv_widx[h]), .wdata(wdat[h]),
                .raddr(priv_raddr), .rdata(priv_rd[h])
            );
            lane_opnd_half #(
                .DEPTH (SHALF), .DATA_W(DATA_W), .NRD(1), .IDX_W(SIDX_W)
            ) u_shr (
                .clk(clk), .rst_n(rst_n), .en(en),
                .we(shr_we[h]), .waddr(shr_widx[h]), .wdata(wdat[h]),
                .raddr(shr_raddr), .rdata(shr_rd[h])
            );
        end
    endgenerate

    // Steering state, two-process
    steer_t steer_d, steer_q;

    always_comb begin
        steer_d = steer_q;
        if (en) begin
            steer_d.par1 = rd_addr1[0];
            steer_d.par2 = rd_addr2[0];
            if (!rd_addr1[SPACE_BIT]) begin
                steer_d.src = SRC_PRIV;
            end else if (rd_addr1[NBR_BIT]) begin
                steer_d.src = SRC_NBR;
            end else begin
                steer_d.src = SRC_LOCAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steer_q <= '{src: SRC_PRIV, par1: 1'b0, par2: 1'b0};
        end else begin
            steer_q <= steer_d;
        end
    end

    // Output selection
    logic [DATA_W-1:0] priv_op1, priv_op2, shr_word;

    assign priv_op1 = steer_q.par1 ? priv_rd[1][DATA_W-1:0]      : priv_rd[0][DATA_W-1:0];
    assign priv_op2 = steer_q.par2 ? priv_rd[1][2*DATA_W-1:DATA_W] : priv_rd[0][2*DATA_W-1:DATA_W];
    assign shr_word = steer_q.par1 ? shr_rd[1] : shr_rd[0];

    always_comb begin
        case (steer_q.src)
            SRC_LOCAL: rd_data1 = shr_word;
            SRC_NBR:   rd_data1 = shr_in;
            default:   rd_data1 = priv_op1;
        endcase
    end

    assign rd_data2 = priv_op2;
    assign shr_out  = share_en ? shr_word : '0;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{wr_addr1[0], wr_addr2[0], rd_addr2[ADDR_W-1:PIDX_W+1]};

    assert_steer_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(steer_q.src));

    assert_priv_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rd_addr1[SPACE_BIT]) |=> (steer_q.src == SRC_PRIV));

    assert_op2_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rd_data2));

    assert_export_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (share_en && steer_q.src == SRC_LOCAL) |-> (shr_out == rd_data1));

endmodule

// File: tb/sim_lane_opnd_buf.sv
`timescale 1ns/1ps
module sim_lane_opnd_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, share_en = 1'b1;
    logic        wr_en1 = 1'b0, wr_en2 = 1'b0;
    logic [7:0]  wr_addr1 = '0, wr_addr2 = '0, rd_addr1 = '0, rd_addr2 = '0;
    logic [15:0] wr_data1 = '0, wr_data2 = '0, shr_in = '0;
    logic [15:0] shr_out, rd_data1, rd_data2;

    int checks = 0;
    int failures = 0;
    logic [15:0] mdl [160];

    always #2 clk = ~clk;

    lane_opnd_buf u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .share_en(share_en),
        .wr_en1(wr_en1), .wr_addr1(wr_addr1), .wr_data1(wr_data1),
        .wr_en2(wr_en2), .wr_addr2(wr_addr2), .wr_data2(wr_data2),
        .rd_addr1(rd_addr1), .rd_addr2(rd_addr2), .shr_in(shr_in),
        .shr_out(shr_out), .rd_data1(rd_data1), .rd_data2(rd_data2)
    );

    typedef struct packed {
        logic [7:0]  a1;
        logic [7:0]  a2;
        logic [15:0] nb;
        logic        sh;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd4,   8'd9,   16'h0000, 1'b1},
        '{8'd7,   8'd3,   16'h0000, 1'b1},
        '{8'd126, 8'd127, 16'h0000, 1'b1},
        '{8'd134, 8'd12,  16'h0000, 1'b1},
        '{8'd159, 8'd133, 16'h0000, 1'b1},
        '{8'd198, 8'd1,   16'hBEEF, 1'b1},
        '{8'd198, 8'd0,   16'h1234, 1'b0},
        '{8'd135, 8'd2,   16'h0000, 1'b0},
        '{8'd0,   8'd0,   16'h0000, 1'b1},
        '{8'd193, 8'd50,  16'hCAFE, 1'b1}
    };

    function automatic logic [15:0] pat(int a);
        return 16'(16'h1000 + a * 3);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_data1", rd_data1, 16'h0);
        check("R1 rd_data2", rd_data2, 16'h0);
        check("R1 shr_out", shr_out, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;

        // Fill all 160 words
        for (int a = 0; a < 160; a += 2) begin
            wr_en1 = 1'b1; wr_addr1 = 8'(a);     wr_data1 = pat(a);
            wr_en2 = 1'b1; wr_addr2 = 8'(a + 1); wr_data2 = pat(a + 1);
            mdl[a] = pat(a); mdl[a + 1] = pat(a + 1);
            tick();
        end
        wr_en1 = 1'b0; wr_en2 = 1'b0;

        // Table sweep: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [15:0] e1, e2, es;
            rd_addr1 = VECS[v].a1; rd_addr2 = VECS[v].a2;
            shr_in = VECS[v].nb; share_en = VECS[v].sh;
            tick();
            if (!VECS[v].a1[7])     e1 = mdl[VECS[v].a1[6:0]];
            else if (VECS[v].a1[6]) e1 = VECS[v].nb;
            else                    e1 = mdl[128 + VECS[v].a1[4:0]];
            e2 = mdl[VECS[v].a2[6:0]];
            es = VECS[v].sh ? mdl[128 + VECS[v].a1[4:0]] : 16'h0;
            check(!VECS[v].a1[7] ? "R5 priv op1" : (VECS[v].a1[6] ? "R7 nbr op1" : "R6 local op1"),
                  rd_data1, e1);
            check("R4 op2 private", rd_data2, e2);
            check("R8 shr_out", shr_out, es);
        end
        // R7: neighbour operand tracks shr_in live
        shr_in = 16'h0F0F;
        #1;
        check("R7 nbr follows shr_in", rd_data1, 16'h0F0F);
        share_en = 1'b1;

        // R9: read and write same word same cycle
        rd_addr1 = 8'd10; rd_addr2 = 8'd11;
        wr_en1 = 1'b1; wr_addr1 = 8'd10; wr_data1 = 16'hAAAA;
        wr_en2 = 1'b1; wr_addr2 = 8'd11; wr_data2 = 16'h5555;
        tick();
        check("R9 old data op1", rd_data1, mdl[10]);
        check("R9 old data op2", rd_data2, mdl[11]);
        mdl[10] = 16'hAAAA; mdl[11] = 16'h5555;
        wr_en1 = 1'b0; wr_en2 = 1'b0;
        tick();
        check("R9 new data op1", rd_data1, 16'hAAAA);
        check("R9 new data op2", rd_data2, 16'h5555);

        // R3: port 2 with even address lands in odd half; port 1 strobe low
        wr_en2 = 1'b1; wr_addr2 = 8'd20; wr_data2 = 16'h7777;
        wr_en1 = 1'b0; wr_addr1 = 8'd22; wr_data1 = 16'h9999;
        tick();
        mdl[21] = 16'h7777;
        // R3: shared write with bit 6 set goes to shared word 132
        wr_en2 = 1'b0;
        wr_en1 = 1'b1; wr_addr1 = 8'd196; wr_data1 = 16'h4444;
        tick();
        mdl[132] = 16'h4444;
        wr_en1 = 1'b0;
        rd_addr1 = 8'd21; rd_addr2 = 8'd22;
        tick();
        check("R3 port2 bit0 ignored", rd_data1, 16'h7777);
        check("R3 strobe low no write", rd_data2, pat(22));
        rd_addr1 = 8'd132; rd_addr2 = 8'd20;
        tick();
        check("R3 shared write bit6 ignored", rd_data1, 16'h4444);
        check("R2 private odd/even split", rd_data2, pat(20));

        // R10: enable low holds outputs and blocks writes
        rd_addr1 = 8'd30; rd_addr2 = 8'd31;
        tick();
        en = 1'b0;
        rd_addr1 = 8'd40; rd_addr2 = 8'd41;
        wr_en1 = 1'b1; wr_addr1 = 8'd30; wr_data1 = 16'hDEAD;
        tick();
        check("R10 op1 hold", rd_data1, pat(30));
        check("R10 op2 hold", rd_data2, pat(31));
        tick();
        check("R10 op1 hold 2", rd_data1, pat(30));
        wr_en1 = 1'b0;
        en = 1'b1;
        rd_addr1 = 8'd30;
        tick();
        check("R10 no write while disabled", rd_data1, pat(30));
        check("R10 op2 resumes", rd_data2, pat(41));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule